// File: doc/BRIEF.md
# Block Copy and Search Engine

This engine runs the per-byte loop behind block-move and block-search operations. Three 16-bit registers are loaded when a command starts: a source pointer, a destination pointer and a byte count. An 8-bit comparand is loaded with them. The engine then works through memory one byte per iteration, using a synchronous single-port memory. An address presented in one cycle returns its read data in the next, and a write happens at the clock edge where the write enable is high.

A command picks one of two operations, copy or search. It also picks whether the pointers step upward or downward, and whether the engine stops after one byte or keeps repeating. A repeating copy runs until the count is used up. A repeating search also ends early on the first byte that equals the comparand. At completion the engine presents the final pointers, the final count, an updated flag byte and a modelled cycle cost. The cost is 21 for every iteration that is followed by another, and 16 for the iteration that ends the command. A one-cycle done pulse marks the end.

Top module: `blk_xfer_engine`

## Requirements
- R1: A copy iteration writes the byte read at the source pointer to the destination pointer. It then moves both pointers by one, upward when `cmdDecrement` is 0 and downward when it is 1, and lowers the count by one.
- R2: A search iteration reads the byte at the source pointer, moves only the source pointer by one in the selected direction and lowers the count by one. The destination pointer is unchanged and nothing is written.
- R3: With `cmdRepeat`=1, a copy keeps iterating until the count reaches zero. With `cmdRepeat`=0, exactly one iteration runs.
- R4: With `cmdRepeat`=1, a search stops after the first iteration that either leaves the count at zero or reads a byte equal to the comparand.
- R5: `cycleCount` at completion equals 21 times the number of iterations followed by another iteration, plus 16 for the final iteration.
- R6: After a copy, flag bit 4 (half-carry) and bit 1 (subtract) are 0. Bits 7, 6 and 0 keep their `flagsIn` values. Bit 2 is 1 when the final count is nonzero and 0 when it is zero.
- R7: After a search, bit 1 is 1 and bit 0 keeps its `flagsIn` value. Bit 6 is 1 when the last byte equals the comparand. Bit 7 is bit 7 of (comparand minus byte). Bit 4 is the borrow out of the low nibble of that subtraction. Bit 2 follows the same rule as in R6.
- R8: A `start` asserted while `busy` is high has no effect on the running command or its results.
- R9: `busy` rises in the cycle after `start` is accepted and falls when `done` rises. `done` is high for exactly one cycle.
- R10: After reset, `busy`, `done` and `memWe` are 0 and the register outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command; sampled only when idle |
| cmdCompare | input | 1 | 1 = search, 0 = copy |
| cmdDecrement | input | 1 | 1 = pointers step down, 0 = up |
| cmdRepeat | input | 1 | 1 = repeat, 0 = single iteration |
| srcIn | input | 16 | Initial source pointer |
| dstIn | input | 16 | Initial destination pointer |
| cntIn | input | 16 | Initial byte count |
| accIn | input | 8 | Comparand for searches |
| flagsIn | input | 8 | Flag byte before the command |
| memAddr | output | 16 | Memory address |
| memWe | output | 1 | Memory write enable |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, one cycle after the address |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| srcOut | output | 16 | Current source pointer |
| dstOut | output | 16 | Current destination pointer |
| cntOut | output | 16 | Current count |
| flagsOut | output | 8 | Updated flag byte |
| cycleCount | output | 16 | Modelled cycle cost of the command |

## Verification
The checker watches several rules on every clock cycle. The count falls by exactly one after each write, and every write targets the destination pointer. `done` lasts one cycle and never overlaps `busy`. At completion, the parity/overflow bit agrees with the final count and the subtract flag is set for searches. A single-iteration command always reports a cost of 16, and the latched command mode holds steady while busy. The bench scenarios cover the rest: the memory contents moved in both directions, the choice between the count and a match as the end of a search, the exact cost of long repeats, and how a start request issued mid-command is handled.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  localparam int FLAG_C  = 0;
  localparam int FLAG_N  = 1;
  localparam int FLAG_PV = 2;
  localparam int FLAG_H  = 4;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_S  = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EXEC = 2'd2
  } xferState_e;

  typedef struct packed {
    logic loadRegs;
    logic execPhase;
  } xferStrobe_t;
endpackage

// File: rtl/blk_xfer_control.sv
module blk_xfer_control
  import blk_xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        keepGoing,
  output xferStrobe_t strobe,
  output logic        busy,
  output logic        done
);
  xferState_e state;
  logic       doneReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        ST_IDLE: if (start) state <= ST_READ;
        ST_READ: state <= ST_EXEC;
        ST_EXEC: begin
          if (keepGoing) begin
            state <= ST_READ;
          end else begin
            state   <= ST_IDLE;
            doneReg <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadRegs  = (state == ST_IDLE) && start;
    strobe.execPhase = (state == ST_EXEC);
  end

  assign busy = (state != ST_IDLE);
  assign done = doneReg;
endmodule

// File: rtl/blk_xfer_datapath.sv
module blk_xfer_datapath
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int CYC_W     = 16,
  parameter int ITER_COST = 21,
  parameter int LAST_COST = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobe_t       strobe,
  input  logic              cmdCompare,
  input  logic              cmdDecrement,
  input  logic              cmdRepeat,
  input  logic [ADDR_W-1:0] srcIn,
  input  logic [ADDR_W-1:0] dstIn,
  input  logic [ADDR_W-1:0] cntIn,
  input  logic [DATA_W-1:0] accIn,
  input  logic [7:0]        flagsIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] srcOut,
  output logic [ADDR_W-1:0] dstOut,
  output logic [ADDR_W-1:0] cntOut,
  output logic [7:0]        flagsOut,
  output logic [CYC_W-1:0]  cycleCount,
  output logic              keepGoing,
  output logic              modeCompare,
  output logic              modeRepeat
);
  localparam logic [ADDR_W-1:0] STEP_UP   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_DOWN = '1;
  localparam logic [CYC_W-1:0]  COST_MID  = CYC_W'(ITER_COST);
  localparam logic [CYC_W-1:0]  COST_END  = CYC_W'(LAST_COST);
  localparam int                NIB_W     = 4;

  logic [ADDR_W-1:0] srcReg, dstReg, cntReg;
  logic [DATA_W-1:0] accReg;
  logic [7:0]        flagsReg;
  logic [CYC_W-1:0]  cycReg;
  logic              modeDown;

  logic [ADDR_W-1:0] stepVal, srcNext, dstNext, cntNext;
  logic [DATA_W-1:0] diff;
  logic [NIB_W:0]    nibbleDiff;
  logic              isMatch, countLeft;
  logic [7:0]        flagsNext;

  assign stepVal    = modeDown ? STEP_DOWN : STEP_UP;
  assign srcNext    = srcReg + stepVal;
  assign dstNext    = dstReg + stepVal;
  assign cntNext    = cntReg - ADDR_W'(1);
  assign countLeft  = (cntNext != '0);
  assign diff       = accReg - memRdata;
  assign nibbleDiff = {1'b0, accReg[NIB_W-1:0]} - {1'b0, memRdata[NIB_W-1:0]};
  assign isMatch    = (diff == '0);
  assign keepGoing  = modeRepeat && countLeft && !(modeCompare && isMatch);

  always_comb begin
    flagsNext          = flagsReg;
    flagsNext[FLAG_PV] = countLeft;
    if (modeCompare) begin
      flagsNext[FLAG_S] = diff[DATA_W-1];
      flagsNext[FLAG_Z] = isMatch;
      flagsNext[FLAG_H] = nibbleDiff[NIB_W];
      flagsNext[FLAG_N] = 1'b1;
    end else begin
      flagsNext[FLAG_H] = 1'b0;
      flagsNext[FLAG_N] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg      <= '0;
      dstReg      <= '0;
      cntReg      <= '0;
      accReg      <= '0;
      flagsReg    <= '0;
      cycReg      <= '0;
      modeCompare <= 1'b0;
      modeDown    <= 1'b0;
      modeRepeat  <= 1'b0;
    end else if (strobe.loadRegs) begin
      srcReg      <= srcIn;
      dstReg      <= dstIn;
      cntReg      <= cntIn;
      accReg      <= accIn;
      flagsReg    <= flagsIn;
      cycReg      <= '0;
      modeCompare <= cmdCompare;
      modeDown    <= cmdDecrement;
      modeRepeat  <= cmdRepeat;
    end else if (strobe.execPhase) begin
      srcReg   <= srcNext;
      cntReg   <= cntNext;
      flagsReg <= flagsNext;
      cycReg   <= cycReg + (keepGoing ? COST_MID : COST_END);
      if (!modeCompare) dstReg <= dstNext;
    end
  end

  assign memAddr    = (strobe.execPhase && !modeCompare) ? dstReg : srcReg;
  assign memWe      = strobe.execPhase && !modeCompare;
  assign memWdata   = memRdata;
  assign srcOut     = srcReg;
  assign dstOut     = dstReg;
  assign cntOut     = cntReg;
  assign flagsOut   = flagsReg;
  assign cycleCount = cycReg;
endmodule

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int CYC_W     = 16,
  parameter int ITER_COST = 21,
  parameter int LAST_COST = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cmdCompare,
  input  logic              cmdDecrement,
  input  logic              cmdRepeat,
  input  logic [ADDR_W-1:0] srcIn,
  input  logic [ADDR_W-1:0] dstIn,
  input  logic [ADDR_W-1:0] cntIn,
  input  logic [DATA_W-1:0] accIn,
  input  logic [7:0]        flagsIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] srcOut,
  output logic [ADDR_W-1:0] dstOut,
  output logic [ADDR_W-1:0] cntOut,
  output logic [7:0]        flagsOut,
  output logic [CYC_W-1:0]  cycleCount
);
  xferStrobe_t strobe;
  logic        keepGoing;
  logic        modeCompare;
  logic        modeRepeat;

  blk_xfer_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .keepGoing (keepGoing),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done)
  );

  blk_xfer_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CYC_W     (CYC_W),
    .ITER_COST (ITER_COST),
    .LAST_COST (LAST_COST)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cmdCompare   (cmdCompare),
    .cmdDecrement (cmdDecrement),
    .cmdRepeat    (cmdRepeat),
    .srcIn        (srcIn),
    .dstIn        (dstIn),
    .cntIn        (cntIn),
    .accIn        (accIn),
    .flagsIn      (flagsIn),
    .memRdata     (memRdata),
    .memAddr      (memAddr),
    .memWe        (memWe),
    .memWdata     (memWdata),
    .srcOut       (srcOut),
    .dstOut       (dstOut),
    .cntOut       (cntOut),
    .flagsOut     (flagsOut),
    .cycleCount   (cycleCount),
    .keepGoing    (keepGoing),
    .modeCompare  (modeCompare),
    .modeRepeat   (modeRepeat)
  );
endmodule

// File: rtl/blk_xfer_checker.sv
module blk_xfer_checker #(
  parameter int ADDR_W    = 16,
  parameter int CYC_W     = 16,
  parameter int LAST_COST = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] dstOut,
  input logic [ADDR_W-1:0] cntOut,
  input logic [7:0]        flagsOut,
  input logic [CYC_W-1:0]  cycleCount,
  input logic              modeCompare,
  input logic              modeRepeat
);
  // R1: each write lands on the destination pointer
  assert_write_target_R1: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr == dstOut));

  // R1: the count falls by one after each copy iteration
  assert_count_drop_R1: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (cntOut == $past(cntOut) - ADDR_W'(1)));

  // R2: a search never writes
  assert_no_write_search_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && modeCompare) |-> !memWe);

  // R5: a single iteration costs the final-iteration figure
  assert_single_cost_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !modeRepeat) |-> (cycleCount == CYC_W'(LAST_COST)));

  // R6: parity/overflow mirrors the remaining count
  assert_pv_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (flagsOut[2] == (cntOut != '0)));

  // R7: searches end with the subtract flag set
  assert_sub_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && modeCompare) |-> flagsOut[1]);

  // R8: the latched mode cannot change while busy
  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(modeCompare));

  // R9: done is a single-cycle pulse outside busy
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind blk_xfer_engine blk_xfer_checker #(
  .ADDR_W    (ADDR_W),
  .CYC_W     (CYC_W),
  .LAST_COST (LAST_COST)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .done        (done),
  .memWe       (memWe),
  .memAddr     (memAddr),
  .dstOut      (dstOut),
  .cntOut      (cntOut),
  .flagsOut    (flagsOut),
  .cycleCount  (cycleCount),
  .modeCompare (modeCompare),
  .modeRepeat  (modeRepeat)
);

// File: tb/blk_xfer_engine_test.sv
module blk_xfer_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        cmdCompare = 1'b0, cmdDecrement = 1'b0, cmdRepeat = 1'b0;
  logic [15:0] srcIn = '0, dstIn = '0, cntIn = '0;
  logic [7:0]  accIn = '0, flagsIn = '0;
  logic [15:0] memAddr;
  logic        memWe;
  logic [7:0]  memWdata, memRdata;
  logic        busy, done;
  logic [15:0] srcOut, dstOut, cntOut, cycleCount;
  logic [7:0]  flagsOut;

  logic        tbWe = 1'b0;
  logic [7:0]  tbAddr = '0, tbData = '0;
  logic [7:0]  ram [256];
  logic [7:0]  model [256];

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [15:0] src, dst, cnt, cyc;
    logic [7:0]  flags;
    string       ptrTag, flagTag;
  } expItem_t;
  expItem_t sbQueue[$];
  int doneSeen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_xfer_engine uut (
    .clk(clk), .rstN(rstN), .start(start), .cmdCompare(cmdCompare),
    .cmdDecrement(cmdDecrement), .cmdRepeat(cmdRepeat), .srcIn(srcIn),
    .dstIn(dstIn), .cntIn(cntIn), .accIn(accIn), .flagsIn(flagsIn),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata),
    .busy(busy), .done(done), .srcOut(srcOut), .dstOut(dstOut), .cntOut(cntOut),
    .flagsOut(flagsOut), .cycleCount(cycleCount)
  );

  always_ff @(posedge clk) begin
    if (tbWe) ram[tbAddr] <= tbData;
    else if (memWe) ram[memAddr[7:0]] <= memWdata;
    memRdata <= ram[memAddr[7:0]];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    tbWe = 1'b1; tbAddr = a; tbData = d;
    model[a] = d;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  // Driver: computes the expected outcome and pushes it to the scoreboard
  task automatic runCmd(input bit cmp, input bit dec, input bit rep,
                        input logic [15:0] s0, input logic [15:0] d0,
                        input logic [15:0] c0, input logic [7:0] acc,
                        input logic [7:0] f0, input bit pokeBusy);
    expItem_t    e;
    logic [15:0] s = s0, d = d0, c = c0, stp, cyc = '0;
    logic [7:0]  f = f0, b, df;
    logic [4:0]  nib;
    bit          more;
    int          startCount;
    stp = dec ? 16'hFFFF : 16'h0001;
    for (int k = 0; k < 300; k++) begin
      b = model[s[7:0]];
      c = c - 16'd1;
      f[2] = (c != 0);
      if (cmp) begin
        df = acc - b;
        nib = {1'b0, acc[3:0]} - {1'b0, b[3:0]};
        f[7] = df[7]; f[6] = (df == 0); f[4] = nib[4]; f[1] = 1'b1;
        more = rep && (c != 0) && (df != 0);
      end else begin
        model[d[7:0]] = b;
        d = d + stp;
        f[4] = 1'b0; f[1] = 1'b0;
        more = rep && (c != 0);
      end
      s = s + stp;
      cyc = cyc + (more ? 16'd21 : 16'd16);
      if (!more) break;
    end
    e.src = s; e.dst = d; e.cnt = c; e.cyc = cyc; e.flags = f;
    e.ptrTag = cmp ? (rep ? "R4" : "R2") : (rep ? "R3" : "R1");
    e.flagTag = cmp ? "R7" : "R6";
    sbQueue.push_back(e);
    startCount = doneSeen;

    @(negedge clk);
    cmdCompare = cmp; cmdDecrement = dec; cmdRepeat = rep;
    srcIn = s0; dstIn = d0; cntIn = c0; accIn = acc; flagsIn = f0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9", "busy after start", 16'(busy), 16'd1);
    if (pokeBusy) begin
      @(negedge clk);
      @(negedge clk);
      cmdCompare = ~cmp; cmdDecrement = ~dec; cmdRepeat = 1'b0;
      srcIn = 16'h00F0; dstIn = 16'h00E0; cntIn = 16'd9; accIn = 8'h55;
      flagsIn = 8'hFF;
      start = 1'b1;   // R8: request while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (doneSeen == startCount) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check(!busy, "R8", "idle after command (late start ignored)", 16'(busy), 16'd0);
  endtask

  task automatic checkRam(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (ram[i] !== model[i]) bad++;
    check(bad == 0, req, "memory image mismatches", 16'(bad), 16'd0);
  endtask

  // Monitor: pops expected items as completions appear
  initial begin
    expItem_t e;
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        if (sbQueue.size() == 0) begin
          check(1'b0, "R9", "unexpected done", 16'd1, 16'd0);
        end else begin
          e = sbQueue.pop_front();
          check(srcOut == e.src, e.ptrTag, "srcOut", srcOut, e.src);
          check(dstOut == e.dst, e.ptrTag, "dstOut", dstOut, e.dst);
          check(cntOut == e.cnt, e.ptrTag, "cntOut", cntOut, e.cnt);
          check(flagsOut == e.flags, e.flagTag, "flagsOut", 16'(flagsOut), 16'(e.flags));
          check(cycleCount == e.cyc, "R5", "cycleCount", cycleCount, e.cyc);
          check(!busy, "R9", "busy low at done", 16'(busy), 16'd0);
        end
        doneSeen++;
        @(negedge clk);
        check(!done, "R9", "done lasts one cycle", 16'(done), 16'd0);
      end
    end
  end

  initial begin
    for (int k = 0; k < WATCHDOG; k++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(!busy && !done && !memWe, "R10", "control outputs after reset",
          {13'd0, busy, done, memWe}, 16'd0);
    check(srcOut == 0 && dstOut == 0 && cntOut == 0 && cycleCount == 0,
          "R10", "register outputs after reset", cntOut, 16'd0);
    for (int i = 0; i < 256; i++) poke(8'(i), 8'(i * 7 + 3));

    // R1 / R6: single copy upward, carry and sign kept
    runCmd(1'b0, 1'b0, 1'b0, 16'h0010, 16'h0080, 16'd3, 8'h00, 8'hD3, 1'b0);
    checkRam("R1");
    // R3: repeated copy upward
    runCmd(1'b0, 1'b0, 1'b1, 16'h0020, 16'h0090, 16'd5, 8'h00, 8'h12, 1'b0);
    checkRam("R3");
    // R3: repeated copy downward with a count of one
    runCmd(1'b0, 1'b1, 1'b1, 16'h0030, 16'h00A0, 16'd1, 8'h00, 8'h01, 1'b0);
    // R3: repeated copy downward, several bytes
    runCmd(1'b0, 1'b1, 1'b1, 16'h0045, 16'h00B8, 16'd6, 8'h00, 8'h00, 1'b0);
    checkRam("R3");
    // R2 / R7: single search, no match
    runCmd(1'b1, 1'b0, 1'b0, 16'h0040, 16'h0070, 16'd4, 8'h05, 8'h01, 1'b0);
    checkRam("R2");
    // R4: search upward, match in the middle
    poke(8'h52, 8'h99);
    runCmd(1'b1, 1'b0, 1'b1, 16'h0050, 16'h0000, 16'd8, 8'h99, 8'h00, 1'b0);
    // R4: search downward, count runs out
    runCmd(1'b1, 1'b1, 1'b1, 16'h0065, 16'h0000, 16'd4, 8'hFE, 8'h01, 1'b0);
    // R4: match on the very last byte
    poke(8'h5A, 8'h3C);
    runCmd(1'b1, 1'b0, 1'b1, 16'h0058, 16'h0000, 16'd3, 8'h3C, 8'h00, 1'b0);
    checkRam("R2");
    // R8: start pulse during a running repeated copy
    runCmd(1'b0, 1'b0, 1'b1, 16'h0008, 16'h00C0, 16'd7, 8'h00, 8'h40, 1'b1);
    checkRam("R8");
    // R8: start pulse during a running search
    runCmd(1'b1, 1'b1, 1'b1, 16'h0038, 16'h0000, 16'd5, 8'h01, 8'h00, 1'b1);
    checkRam("R8");

    repeat (4) @(negedge clk);
    check(sbQueue.size() == 0, "R9", "outstanding results", 16'(sbQueue.size()), 16'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule